// File: doc/BRIEF.md
# PTP Event Frame Timestamper

This block sits on the byte stream between an Ethernet PHY and MAC, with one independent lane for received traffic and one for transmitted traffic. Each lane forwards its 8-bit valid/data stream with no added delay. Alongside that, it watches for the start-of-frame delimiter and latches the free-running local time on that exact cycle. The lane does not yet know whether the frame matters. It then reads fixed header offsets to decide whether the frame is a UDP/IPv4 precision-time event message, meaning a SYNC or a DELAY_REQUEST.

When a frame qualifies, the lane keeps the latched time and stores it in a small record FIFO, together with the message-type code and the 16-bit sequence number. A host drains this FIFO one record at a time. When a frame does not qualify, or is cut short, the latched time is thrown away.

The local clock is an input, so the block only samples it. Correction filtering, the servo loop and the MAC itself live elsewhere.

Each lane's classifier is a four-state machine:
- IDLE waits for a frame.
- PRE has seen preamble bytes.
- HDR counts header bytes and checks fields.
- DRAIN ignores the rest of a frame until valid drops.

The named transitions are:
- IDLE→PRE on a valid 0x55.
- IDLE→DRAIN on any other valid byte.
- PRE→PRE on 0x55.
- PRE→HDR on 0xD5, which also captures the time.
- PRE→DRAIN on any other byte.
- HDR→DRAIN on a field mismatch, or on the final sequence byte, which also pushes the record.
- HDR→IDLE, PRE→IDLE and DRAIN→IDLE when valid drops.

Top module: `ptp_event_stamper`

## Requirements
- R1: After reset neither lane presents a record (`*_rec_valid` low) and both overflow flags are low.
- R2: In each lane, `*_out_valid`/`*_out_data` equal `*_in_valid`/`*_in_data` in the same cycle, for every byte.
- R3: Start of frame is a valid 0xD5 byte immediately preceded by one or more valid 0x55 bytes. The stored timestamp is the `local_time` value present during that 0xD5 cycle.
- R4: Bytes are indexed from 0 on the first byte after 0xD5. A frame qualifies only if all of the following hold:
  - byte 12 is 0x08 and byte 13 is 0x00;
  - byte 14 is 0x45;
  - byte 23 is 0x11;
  - byte 36 is 0x01 and byte 37 is 0x3F;
  - the low nibble of byte 42 is 0 (SYNC) or 1 (DELAY_REQUEST).
- R5: A qualifying frame yields a record whose type is the low nibble of byte 42 and whose sequence is {byte 72, byte 73}. The record becomes visible on the cycle after byte 73. Later bytes of the frame have no effect.
- R6: A frame that fails any check in R4, including a frame whose type nibble is some other code, produces no record.
- R7: A frame whose valid drops before byte 73 produces no record. A burst that starts with a byte other than 0x55 is ignored until valid drops.
- R8: The receive and transmit lanes capture, classify, queue and flag overflow independently of each other.
- R9: Each FIFO holds 4 records in arrival order. While `*_rec_valid` is high the oldest record is shown on `*_rec_*`. A cycle with `*_rec_pop` high removes it. A pop while empty is ignored.
- R10: A record that arrives while its FIFO holds 4 entries is dropped, even if a pop happens in the same cycle. It sets that lane's overflow flag, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_time | input | TS_W | Free-running local time |
| rx_in_valid | input | 1 | Receive byte valid from PHY |
| rx_in_data | input | 8 | Receive byte from PHY |
| rx_out_valid | output | 1 | Receive byte valid to MAC |
| rx_out_data | output | 8 | Receive byte to MAC |
| rx_rec_valid | output | 1 | Receive FIFO holds a record |
| rx_rec_ts | output | TS_W | Oldest receive record: timestamp |
| rx_rec_type | output | 4 | Oldest receive record: message type |
| rx_rec_seq | output | 16 | Oldest receive record: sequence number |
| rx_rec_pop | input | 1 | Remove the oldest receive record |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_in_valid | input | 1 | Transmit byte valid from MAC |
| tx_in_data | input | 8 | Transmit byte from MAC |
| tx_out_valid | output | 1 | Transmit byte valid to PHY |
| tx_out_data | output | 8 | Transmit byte to PHY |
| tx_rec_valid | output | 1 | Transmit FIFO holds a record |
| tx_rec_ts | output | TS_W | Oldest transmit record: timestamp |
| tx_rec_type | output | 4 | Oldest transmit record: message type |
| tx_rec_seq | output | 16 | Oldest transmit record: sequence number |
| tx_rec_pop | input | 1 | Remove the oldest transmit record |
| tx_ovf | output | 1 | Sticky transmit overflow |

## Verification
The assertions assume a few things about each lane's inputs. Valid drops for at least one cycle between frames. The host pops only through `*_rec_pop`. Local time is free-running and never written from inside the block.

The stimulus keeps to these assumptions:
- Every frame is followed by idle cycles.
- Pops are issued by a periodic pattern that is sometimes switched off, which fills a FIFO to the point of overflow.
- Legal and illegal frames are sent on both lanes at once, so any coupling between the lanes would show.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_DRAIN
    } cls_state_e;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    // Header byte offsets, counted from the first byte after the delimiter
    localparam int OFF_ETH_HI   = 12;
    localparam int OFF_ETH_LO   = 13;
    localparam int OFF_VIHL     = 14;
    localparam int OFF_PROTO    = 23;
    localparam int OFF_DPORT_HI = 36;
    localparam int OFF_DPORT_LO = 37;
    localparam int OFF_MTYPE    = 42;
    localparam int OFF_SEQ_HI   = 72;
    localparam int OFF_SEQ_LO   = 73;

    localparam logic [7:0] VAL_ETH_HI   = 8'h08;
    localparam logic [7:0] VAL_ETH_LO   = 8'h00;
    localparam logic [7:0] VAL_VIHL     = 8'h45;
    localparam logic [7:0] VAL_PROTO    = 8'h11;
    localparam logic [7:0] VAL_DPORT_HI = 8'h01;
    localparam logic [7:0] VAL_DPORT_LO = 8'h3F;
    localparam logic [3:0] MAX_EVENT    = 4'd1;

    localparam int IDX_W = $clog2(OFF_SEQ_LO + 1);

endpackage

// File: rtl/ptp_frame_classifier.sv
module ptp_frame_classifier
    import ptp_stamp_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic [TS_W-1:0] now,
    output logic            push,
    output logic [TS_W-1:0] push_ts,
    output logic [3:0]      push_type,
    output logic [15:0]     push_seq
);

    cls_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [TS_W-1:0]  ts_q;
    logic [3:0]       type_q;
    logic [7:0]       seq_hi_q;
    logic             field_bad;
    logic             last_byte;
    logic             capture;

    // Field check for the byte at the current header index
    always_comb begin
        field_bad = 1'b0;
        case (int'(idx_q))
            OFF_ETH_HI:   field_bad = (in_data != VAL_ETH_HI);
            OFF_ETH_LO:   field_bad = (in_data != VAL_ETH_LO);
            OFF_VIHL:     field_bad = (in_data != VAL_VIHL);
            OFF_PROTO:    field_bad = (in_data != VAL_PROTO);
            OFF_DPORT_HI: field_bad = (in_data != VAL_DPORT_HI);
            OFF_DPORT_LO: field_bad = (in_data != VAL_DPORT_LO);
            OFF_MTYPE:    field_bad = (in_data[3:0] > MAX_EVENT);
            default:      field_bad = 1'b0;
        endcase
    end

    assign last_byte = (idx_q == IDX_W'(OFF_SEQ_LO));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = (in_data == PRE_BYTE) ? ST_PRE : ST_DRAIN;
            end
            ST_PRE: begin
                if (!in_valid)                state_d = ST_IDLE;
                else if (in_data == SFD_BYTE) state_d = ST_HDR;
                else if (in_data != PRE_BYTE) state_d = ST_DRAIN;
            end
            ST_HDR: begin
                if (!in_valid)                  state_d = ST_IDLE;
                else if (field_bad || last_byte) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!in_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        capture = 1'b0;
        push    = 1'b0;
        unique case (state_q)
            ST_PRE:   capture = in_valid && (in_data == SFD_BYTE);
            ST_HDR:   push    = in_valid && !field_bad && last_byte;
            ST_IDLE,
            ST_DRAIN: ;
            default:  ;
        endcase
    end

    // Capture registers and header index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            ts_q     <= '0;
            type_q   <= '0;
            seq_hi_q <= '0;
        end else begin
            if (capture) begin
                ts_q  <= now;
                idx_q <= '0;
            end else if (state_q == ST_HDR && in_valid) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_HDR && in_valid && int'(idx_q) == OFF_MTYPE)
                type_q <= in_data[3:0];
            if (state_q == ST_HDR && in_valid && int'(idx_q) == OFF_SEQ_HI)
                seq_hi_q <= in_data;
        end
    end

    assign push_ts   = ts_q;
    assign push_type = type_q;
    assign push_seq  = {seq_hi_q, in_data};

endmodule

// File: rtl/ptp_record_fifo.sv
module ptp_record_fifo #(
    parameter int W     = 84,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd,
    output logic         not_empty,
    output logic [W-1:0] head,
    output logic         ovf
);

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_wr, do_rd;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign not_empty = (cnt_q != '0);
    assign do_wr     = wr && !full;
    assign do_rd     = rd && not_empty;
    assign head      = mem[rp_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp_q <= (int'(wp_q) == DEPTH - 1) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (int'(rp_q) == DEPTH - 1) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
            if (wr && full) ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

endmodule

// File: rtl/ptp_stamp_lane.sv
module ptp_stamp_lane #(
    parameter int TS_W  = 64,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            rec_valid,
    output logic [TS_W-1:0] rec_ts,
    output logic [3:0]      rec_type,
    output logic [15:0]     rec_seq,
    input  logic            rec_pop,
    output logic            ovf
);

    localparam int REC_W = TS_W + 4 + 16;

    logic             push;
    logic [TS_W-1:0]  p_ts;
    logic [3:0]       p_type;
    logic [15:0]      p_seq;
    logic [REC_W-1:0] head;

    // Zero-latency forwarding
    assign out_valid = in_valid;
    assign out_data  = in_data;

    ptp_frame_classifier #(.TS_W(TS_W)) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .now       (now),
        .push      (push),
        .push_ts   (p_ts),
        .push_type (p_type),
        .push_seq  (p_seq)
    );

    ptp_record_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (push),
        .wr_data   ({p_ts, p_type, p_seq}),
        .rd        (rec_pop),
        .not_empty (rec_valid),
        .head      (head),
        .ovf       (ovf)
    );

    assign {rec_ts, rec_type, rec_seq} = head;

endmodule

// File: rtl/ptp_event_stamper.sv
module ptp_event_stamper #(
    parameter int TS_W  = 64,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] local_time,
    input  logic            rx_in_valid,
    input  logic [7:0]      rx_in_data,
    output logic            rx_out_valid,
    output logic [7:0]      rx_out_data,
    output logic            rx_rec_valid,
    output logic [TS_W-1:0] rx_rec_ts,
    output logic [3:0]      rx_rec_type,
    output logic [15:0]     rx_rec_seq,
    input  logic            rx_rec_pop,
    output logic            rx_ovf,
    input  logic            tx_in_valid,
    input  logic [7:0]      tx_in_data,
    output logic            tx_out_valid,
    output logic [7:0]      tx_out_data,
    output logic            tx_rec_valid,
    output logic [TS_W-1:0] tx_rec_ts,
    output logic [3:0]      tx_rec_type,
    output logic [15:0]     tx_rec_seq,
    input  logic            tx_rec_pop,
    output logic            tx_ovf
);

    ptp_stamp_lane #(.TS_W(TS_W), .DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (local_time),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .out_valid (rx_out_valid),
        .out_data  (rx_out_data),
        .rec_valid (rx_rec_valid),
        .rec_ts    (rx_rec_ts),
        .rec_type  (rx_rec_type),
        .rec_seq   (rx_rec_seq),
        .rec_pop   (rx_rec_pop),
        .ovf       (rx_ovf)
    );

    ptp_stamp_lane #(.TS_W(TS_W), .DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (local_time),
        .in_valid  (tx_in_valid),
        .in_data   (tx_in_data),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data),
        .rec_valid (tx_rec_valid),
        .rec_ts    (tx_rec_ts),
        .rec_type  (tx_rec_type),
        .rec_seq   (tx_rec_seq),
        .rec_pop   (tx_rec_pop),
        .ovf       (tx_ovf)
    );

endmodule

// File: rtl/ptp_event_stamper_chk.sv
module ptp_event_stamper_chk #(
    parameter int TS_W  = 64,
    parameter int DEPTH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_in_valid,
    input logic            rx_rec_valid,
    input logic [TS_W-1:0] rx_rec_ts,
    input logic [3:0]      rx_rec_type,
    input logic [15:0]     rx_rec_seq,
    input logic            rx_rec_pop,
    input logic            rx_ovf,
    input logic            tx_in_valid,
    input logic            tx_rec_valid,
    input logic [TS_W-1:0] tx_rec_ts,
    input logic [3:0]      tx_rec_type,
    input logic [15:0]     tx_rec_seq,
    input logic            tx_rec_pop,
    input logic            tx_ovf
);

    p_rx_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> rx_ovf);
    p_tx_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    p_rx_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rec_valid && !rx_rec_pop |=> rx_rec_valid && $stable(rx_rec_ts)
            && $stable(rx_rec_type) && $stable(rx_rec_seq));
    p_tx_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rec_valid && !tx_rec_pop |=> tx_rec_valid && $stable(tx_rec_ts)
            && $stable(tx_rec_type) && $stable(tx_rec_seq));

    p_rx_drain_by_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_rec_valid) |-> $past(rx_rec_pop));
    p_tx_drain_by_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_rec_valid) |-> $past(tx_rec_pop));

    p_rx_event_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rec_valid |-> rx_rec_type <= 4'd1);
    p_tx_event_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rec_valid |-> tx_rec_type <= 4'd1);

    p_rx_rec_from_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rec_valid) |-> $past(rx_in_valid));
    p_tx_rec_from_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rec_valid) |-> $past(tx_in_valid));

endmodule

bind ptp_event_stamper ptp_event_stamper_chk #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_ptp_event_stamper.sv
module tb_ptp_event_stamper;

    localparam int TS_W = 64;

    typedef logic [7:0] bq_t[$];
    typedef struct {
        logic [TS_W-1:0] ts;
        logic [3:0]      ty;
        logic [15:0]     sq;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [TS_W-1:0] now = '0;
    logic       in_v [2];
    logic [7:0] in_d [2];
    logic       pop [2];
    logic       pop_en [2];
    logic       out_v [2];
    logic [7:0] out_d [2];
    logic       rv [2];
    logic [TS_W-1:0] rts [2];
    logic [3:0] rty [2];
    logic [15:0] rsq [2];
    logic       ovf [2];

    int total = 0;
    int bad = 0;
    int cyc = 0;

    ptp_event_stamper #(.TS_W(TS_W), .DEPTH(4)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .local_time   (now),
        .rx_in_valid  (in_v[0]),
        .rx_in_data   (in_d[0]),
        .rx_out_valid (out_v[0]),
        .rx_out_data  (out_d[0]),
        .rx_rec_valid (rv[0]),
        .rx_rec_ts    (rts[0]),
        .rx_rec_type  (rty[0]),
        .rx_rec_seq   (rsq[0]),
        .rx_rec_pop   (pop[0]),
        .rx_ovf       (ovf[0]),
        .tx_in_valid  (in_v[1]),
        .tx_in_data   (in_d[1]),
        .tx_out_valid (out_v[1]),
        .tx_out_data  (out_d[1]),
        .tx_rec_valid (rv[1]),
        .tx_rec_ts    (rts[1]),
        .tx_rec_type  (rty[1]),
        .tx_rec_seq   (rsq[1]),
        .tx_rec_pop   (pop[1]),
        .tx_ovf       (ovf[1])
    );

    // ---------------- reference model ----------------
    int          m_mode [2];          // 0 idle, 1 preamble, 2 body, 3 ignore
    logic [7:0]  m_body [2][$];
    logic [TS_W-1:0] m_stamp [2];
    rec_t        m_q [2][$];
    bit          m_ovf [2];

    function automatic bit byte_bad(int i, logic [7:0] b);
        case (i)
            12: return b != 8'h08;
            13: return b != 8'h00;
            14: return b != 8'h45;
            23: return b != 8'h11;
            36: return b != 8'h01;
            37: return b != 8'h3F;
            42: return b[3:0] > 4'd1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step(int d);
        bit full_before;
        bit make;
        rec_t r;
        full_before = (m_q[d].size() == 4);
        make = 1'b0;
        if (pop[d] && m_q[d].size() > 0) void'(m_q[d].pop_front());
        if (!in_v[d]) begin
            m_mode[d] = 0;
            m_body[d].delete();
        end else begin
            case (m_mode[d])
                0: m_mode[d] = (in_d[d] == 8'h55) ? 1 : 3;
                1: begin
                    if (in_d[d] == 8'hD5) begin
                        m_mode[d] = 2;
                        m_stamp[d] = now;
                        m_body[d].delete();
                    end else if (in_d[d] != 8'h55) begin
                        m_mode[d] = 3;
                    end
                end
                2: begin
                    m_body[d].push_back(in_d[d]);
                    if (byte_bad(m_body[d].size() - 1, in_d[d])) m_mode[d] = 3;
                    else if (m_body[d].size() == 74) begin
                        make = 1'b1;
                        m_mode[d] = 3;
                    end
                end
                default: ;
            endcase
        end
        if (make) begin
            r.ts = m_stamp[d];
            r.ty = m_body[d][42][3:0];
            r.sq = {m_body[d][72], m_body[d][73]};
            if (full_before) m_ovf[d] = 1'b1;
            else m_q[d].push_back(r);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_mode[d] = 0;
                m_body[d].delete();
                m_q[d].delete();
                m_ovf[d] = 1'b0;
            end
        end else begin
            for (int d = 0; d < 2; d++) model_step(d);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                chk(out_v[d] == in_v[d], "R2", "out_valid", 64'(out_v[d]), 64'(in_v[d]));
                chk(out_d[d] == in_d[d], "R2", "out_data", 64'(out_d[d]), 64'(in_d[d]));
                chk(rv[d] == (m_q[d].size() > 0), "R9", "rec_valid",
                    64'(rv[d]), 64'(m_q[d].size() > 0));
                if (rv[d] && m_q[d].size() > 0) begin
                    chk(rts[d] == m_q[d][0].ts, "R3", "rec_ts", rts[d], m_q[d][0].ts);
                    chk(rty[d] == m_q[d][0].ty, "R5", "rec_type", 64'(rty[d]), 64'(m_q[d][0].ty));
                    chk(rsq[d] == m_q[d][0].sq, "R5", "rec_seq", 64'(rsq[d]), 64'(m_q[d][0].sq));
                end
                chk(ovf[d] == m_ovf[d], "R10", "ovf", 64'(ovf[d]), 64'(m_ovf[d]));
            end
        end
    end

    // ---------------- drivers ----------------
    always begin
        @(posedge clk);
        #1;
        now = now + 64'd3;
        for (int d = 0; d < 2; d++) pop[d] = pop_en[d] && (cyc % 3 != 1);
    end

    // variant: 0 good, 1 bad port, 2 bad ethertype, 3 bad version/IHL, 4 bad protocol
    function automatic bq_t mk_frame(int npre, int ty, int seq, int variant, int len);
        bq_t q;
        for (int i = 0; i < npre; i++) q.push_back(8'h55);
        q.push_back(8'hD5);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(i * 7 + 3);
            case (i)
                12: b = (variant == 2) ? 8'h86 : 8'h08;
                13: b = 8'h00;
                14: b = (variant == 3) ? 8'h46 : 8'h45;
                23: b = (variant == 4) ? 8'h06 : 8'h11;
                36: b = 8'h01;
                37: b = (variant == 1) ? 8'h40 : 8'h3F;
                42: b = {4'h2, 4'(ty)};
                72: b = 8'(seq >> 8);
                73: b = 8'(seq);
                default: ;
            endcase
            q.push_back(b);
        end
        return q;
    endfunction

    task automatic send(int d, bq_t q);
        foreach (q[i]) begin
            @(posedge clk);
            #1;
            in_v[d] = 1'b1;
            in_d[d] = q[i];
        end
        @(posedge clk);
        #1;
        in_v[d] = 1'b0;
        in_d[d] = 8'h00;
        repeat (2) @(posedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int d = 0; d < 2; d++) begin
            in_v[d] = 1'b0;
            in_d[d] = 8'h00;
            pop[d] = 1'b0;
            pop_en[d] = 1'b0;
        end
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk(rv[0] == 1'b0 && rv[1] == 1'b0, "R1", "rec_valid after reset", 64'({rv[0], rv[1]}), 0);
        chk(ovf[0] == 1'b0 && ovf[1] == 1'b0, "R1", "ovf after reset", 64'({ovf[0], ovf[1]}), 0);

        pop_en[0] = 1'b1;
        pop_en[1] = 1'b1;
        // R4 R5 R6 R7 R8: mixed frames on both lanes at once
        fork
            begin
                send(0, mk_frame(7, 0, 16'h0101, 0, 80));   // SYNC
                send(0, mk_frame(3, 1, 16'h0202, 0, 74));   // DELAY_REQUEST
                send(0, mk_frame(7, 8, 16'h0303, 0, 80));   // other type, R6
                send(0, mk_frame(7, 0, 16'h0404, 1, 80));   // wrong port, R6
                send(0, mk_frame(7, 0, 16'h0505, 2, 80));   // wrong ethertype, R6
                send(0, mk_frame(7, 0, 16'h0606, 0, 50));   // truncated, R7
                send(0, mk_frame(0, 0, 16'h0707, 0, 80));   // no preamble, R7
                send(0, mk_frame(7, 0, 16'h0808, 3, 80));   // wrong version, R6
                send(0, mk_frame(1, 1, 16'hBEEF, 0, 80));   // single preamble byte, R3
            end
            begin
                send(1, mk_frame(7, 1, 16'h1010, 0, 90));
                send(1, mk_frame(7, 0, 16'h1111, 4, 80));   // wrong protocol
                send(1, mk_frame(7, 0, 16'h1212, 0, 73));   // one byte short, R7
                send(1, mk_frame(5, 0, 16'h1313, 0, 76));
            end
        join
        idle(20);
        chk(rv[0] == 1'b0, "R9", "rx drained", 64'(rv[0]), 0);

        // R10: fill the transmit FIFO without popping, R8: receive lane unaffected
        pop_en[1] = 1'b0;
        for (int k = 0; k < 6; k++) send(1, mk_frame(7, k % 2, 16'h2000 + k, 0, 74));
        idle(3);
        chk(ovf[1] == 1'b1, "R10", "tx overflow set", 64'(ovf[1]), 1);
        chk(ovf[0] == 1'b0, "R8", "rx overflow untouched", 64'(ovf[0]), 0);
        chk(rv[1] == 1'b1, "R9", "tx holds records", 64'(rv[1]), 1);
        chk(rsq[1] == 16'h2000, "R9", "tx oldest first", 64'(rsq[1]), 64'h2000);
        pop_en[1] = 1'b1;
        idle(20);
        chk(rv[1] == 1'b0, "R9", "tx drained", 64'(rv[1]), 0);
        chk(ovf[1] == 1'b1, "R10", "tx overflow stays", 64'(ovf[1]), 1);

        send(0, mk_frame(7, 0, 16'hCAFE, 0, 74));
        idle(10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule